// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog with two countdown stages behind a small register port. Software writes a first-stage and a second-stage preload value, then turns the watchdog on through a mode register. The first stage counts down from its preload. When it runs out, it pulses an interrupt and hands over to the second stage. When the second stage runs out, the block records a timeout flag and, when the configuration allows it, requests a system reset for one cycle.

The preload registers and the kick/status register are guarded. Each guarded write must follow a two-write key sequence to the status offset. Any other write to the guarded window throws the sequence away, and each accepted write uses it up. A separate mode register holds the enable bit, a free-running bit and a lock bit. Once the lock bit is set it stays set until reset and freezes the other two bits.

Counting advances on a `tick_i` strobe. A configuration bit chooses between one count per tick (fast) and one count per `SLOW_DIV` ticks (slow).

Top module: `wdog_top`

## Requirements
- R1: The guarded window opens only after 0x80 and then 0x86 are written, each as the full data word, to offset 0xC. The 0x86 write opens it only when it directly follows the 0x80 write.
- R2: Any other write to offsets 0x0 to 0xF closes the window. A guarded write that is accepted also closes it, so each guarded write needs a fresh key sequence.
- R3: With the window open, a write to offset 0x0 sets the first-stage preload and a write to offset 0x4 sets the second-stage preload. Each takes only data bits 19:0.
- R4: After reset, offsets 0xC, 0x10 and 0x14 read zero, both outputs are low, and both preloads hold 0xFFFFF.
- R5: With the window open, a write to offset 0xC with bit 8 set restarts counting from the first-stage preload, including from the second stage. Without the key sequence the same write has no effect.
- R6: Offset 0xC reads 0x1200 while the timeout flag is set and 0 otherwise. With the window open, a write to 0xC with bit 9 or bit 12 set clears the flag.
- R7: Configuration register at offset 0x10: bit 5 set disables reset requests, and bit 2 set selects the fast rate. Both bits read back at the same positions.
- R8: Mode register at offset 0x14: bit 0 is lock, bit 1 is enable and bit 2 is free-run. All three read back at the same positions.
- R9: A 0-to-1 change of enable loads the first-stage preload P1. The stage expires on the (P1+1)-th counted tick and drives `irq_o` high for exactly one cycle.
- R10: The second stage then expires after P2+1 counted ticks. It sets the timeout flag and pulses `rst_req_o` for one cycle only when reset requests are enabled and free-run is off. Counting then resumes from P1.
- R11: Once lock is set, it stays set until reset, and writes to the mode register no longer change enable or free-run.
- R12: At the slow rate, one count happens per `SLOW_DIV` ticks of `tick_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write byte offset |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 5 | Read byte offset |
| rd_data_o | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | First-stage expiry pulse |
| rst_req_o | output | 1 | Second-stage reset request pulse |

## Verification
The bench sweeps every pair of small preloads at the fast rate and several at the slow rate. It counts the ticks to each expiry, so an off-by-one in the zero test or the divider shows up directly as a wrong count. It also attacks the key sequence:
- a lone 0x86;
- a stray window write between the two key bytes;
- reuse of a key that was already spent.

A design that leaked any of these would take a preload it should have ignored. Further cases are kicks issued in the second stage, which a wrong design would let run on into a reset request, and mode writes after lock, which a wrong design would let turn the dog off. The flag clear is tried through each of its two bits, and the reset gating through both the disable bit and free-run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W = 5;
    localparam int PRE_W  = 20;

    localparam logic [ADDR_W-1:0] OFS_PRE1 = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PRE2 = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_KEY  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_MODE = 5'h14;

    localparam logic [15:0] KEY_FIRST  = 16'h0080;
    localparam logic [15:0] KEY_SECOND = 16'h0086;
    localparam logic [15:0] FLAG_WORD  = 16'h1200;

    typedef enum logic [1:0] {
        KEY_SHUT = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_e;

    typedef enum logic [1:0] {
        STG_IDLE = 2'd0,
        STG_ONE  = 2'd1,
        STG_TWO  = 2'd2
    } stage_e;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pre1_we,
    output logic              pre2_we,
    output logic              kick,
    output logic              flag_clr
);
    typedef struct packed {
        key_e key;
    } key_s;

    key_s key_d, key_q;
    logic in_window;

    always_comb begin
        key_d     = key_q;
        pre1_we   = 1'b0;
        pre2_we   = 1'b0;
        kick      = 1'b0;
        flag_clr  = 1'b0;
        in_window = (wr_addr < OFS_CFG);
        if (wr_en && in_window) begin
            if (wr_addr == OFS_KEY && wr_data == DATA_W'(KEY_FIRST)) begin
                key_d.key = KEY_HALF;
            end else if (wr_addr == OFS_KEY && wr_data == DATA_W'(KEY_SECOND)
                         && key_q.key == KEY_HALF) begin
                key_d.key = KEY_OPEN;
            end else begin
                if (key_q.key == KEY_OPEN) begin
                    case (wr_addr)
                        OFS_PRE1: pre1_we = 1'b1;
                        OFS_PRE2: pre2_we = 1'b1;
                        OFS_KEY: begin
                            kick     = wr_data[8];
                            flag_clr = wr_data[9] | wr_data[12];
                        end
                        default: ;
                    endcase
                end
                key_d.key = KEY_SHUT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) key_q <= '{key: KEY_SHUT};
        else        key_q <= key_d;
    end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic mode_we,
    input  logic bit0,
    input  logic bit1,
    input  logic bit2,
    input  logic bit5,
    output logic locked,
    output logic enabled,
    output logic free_run,
    output logic reboot_dis,
    output logic fast,
    output logic start
);
    typedef struct packed {
        logic locked;
        logic enabled;
        logic free_run;
        logic reboot_dis;
        logic fast;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        start = 1'b0;
        if (cfg_we) begin
            ctl_d.reboot_dis = bit5;
            ctl_d.fast       = bit2;
        end
        if (mode_we && !ctl_q.locked) begin
            ctl_d.locked   = bit0;
            ctl_d.enabled  = bit1;
            ctl_d.free_run = bit2;
            start          = bit1 && !ctl_q.enabled;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign locked     = ctl_q.locked;
    assign enabled    = ctl_q.enabled;
    assign free_run   = ctl_q.free_run;
    assign reboot_dis = ctl_q.reboot_dis;
    assign fast       = ctl_q.fast;
endmodule

// File: rtl/wdog_rate.sv
module wdog_rate #(
    parameter int SLOW_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fast,
    input  logic run,
    output logic step
);
    localparam int DIV_W = $clog2(SLOW_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } rate_s;

    rate_s rt_d, rt_q;

    always_comb begin
        rt_d = rt_q;
        step = 1'b0;
        if (!run || fast) begin
            rt_d.div = '0;
            step     = run && tick;
        end else if (tick) begin
            if (rt_q.div == DIV_LAST) begin
                rt_d.div = '0;
                step     = 1'b1;
            end else begin
                rt_d.div = rt_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    input  logic             start,
    input  logic             enabled,
    input  logic             kick,
    input  logic             step,
    input  logic             reboot_ok,
    input  logic             flag_clr,
    output logic             irq,
    output logic             rst_req,
    output logic             flag
);
    typedef struct packed {
        stage_e           stage;
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst;
        logic             flag;
    } cnt_s;

    cnt_s c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        c_d.rst = 1'b0;
        if (flag_clr) c_d.flag = 1'b0;
        if (start) begin
            c_d.stage = STG_ONE;
            c_d.cnt   = pre1;
        end else if (!enabled) begin
            c_d.stage = STG_IDLE;
        end else if (kick) begin
            c_d.stage = STG_ONE;
            c_d.cnt   = pre1;
        end else if (step && c_q.stage != STG_IDLE) begin
            if (c_q.cnt != '0) begin
                c_d.cnt = c_q.cnt - 1'b1;
            end else if (c_q.stage == STG_ONE) begin
                c_d.irq   = 1'b1;
                c_d.stage = STG_TWO;
                c_d.cnt   = pre2;
            end else begin
                c_d.flag  = 1'b1;
                c_d.rst   = reboot_ok;
                c_d.stage = STG_ONE;
                c_d.cnt   = pre1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{stage: STG_IDLE, cnt: '0, irq: 1'b0, rst: 1'b0, flag: 1'b0};
        else        c_q <= c_d;
    end

    assign irq     = c_q.irq;
    assign rst_req = c_q.rst;
    assign flag    = c_q.flag;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = PRE_W,
    parameter int SLOW_DIV = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] p1;
        logic [CNT_W-1:0] p2;
    } pre_s;

    pre_s pre_d, pre_q;

    logic pre1_we, pre2_we, kick, flag_clr;
    logic locked, enabled, free_run, reboot_dis, fast, start;
    logic step, flag;
    logic cfg_we, mode_we;

    assign cfg_we  = wr_en_i && (wr_addr_i == OFS_CFG);
    assign mode_we = wr_en_i && (wr_addr_i == OFS_MODE);

    wdog_unlock #(.DATA_W(DATA_W)) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .pre1_we(pre1_we), .pre2_we(pre2_we),
        .kick(kick), .flag_clr(flag_clr)
    );

    wdog_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mode_we(mode_we),
        .bit0(wr_data_i[0]), .bit1(wr_data_i[1]), .bit2(wr_data_i[2]),
        .bit5(wr_data_i[5]), .locked(locked), .enabled(enabled),
        .free_run(free_run), .reboot_dis(reboot_dis), .fast(fast), .start(start)
    );

    wdog_rate #(.SLOW_DIV(SLOW_DIV)) u_rate (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .fast(fast),
        .run(enabled), .step(step)
    );

    wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .pre1(pre_q.p1), .pre2(pre_q.p2),
        .start(start), .enabled(enabled), .kick(kick), .step(step),
        .reboot_ok(!reboot_dis && !free_run), .flag_clr(flag_clr),
        .irq(irq_o), .rst_req(rst_req_o), .flag(flag)
    );

    always_comb begin
        pre_d = pre_q;
        if (pre1_we) pre_d.p1 = wr_data_i[CNT_W-1:0];
        if (pre2_we) pre_d.p2 = wr_data_i[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '1;
        else        pre_q <= pre_d;
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            OFS_KEY:  rd_data_o = flag ? DATA_W'(FLAG_WORD) : '0;
            OFS_CFG:  rd_data_o = DATA_W'({reboot_dis, 2'b00, fast, 2'b00});
            OFS_MODE: rd_data_o = DATA_W'({free_run, enabled, locked});
            default:  rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic rst_req,
    input logic locked,
    input logic enabled,
    input logic free_run,
    input logic reboot_dis,
    input logic flag
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R10
    AST_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(!free_run && !reboot_dis)); // R10
    AST_RST_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> flag); // R10
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R11
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(enabled) && $stable(free_run))); // R11
endmodule

bind wdog_top wdog_checker u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq_o), .rst_req(rst_req_o),
    .locked(locked), .enabled(enabled), .free_run(free_run),
    .reboot_dis(reboot_dis), .flag(flag)
);

// File: tb/wdog_top_bench.sv
module wdog_top_bench;
    localparam int DW  = 32;
    localparam int DIV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [4:0]    wr_addr_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic [4:0]    rd_addr_i = '0;
    logic [DW-1:0] rd_data_o;
    logic          irq_o, rst_req_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    wdog_top #(.DATA_W(DW), .SLOW_DIV(DIV)) u_wdog_top (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        rd_addr_i = a;
        #1;
        v = int'(rd_data_o);
    endtask

    task automatic key();
        wr(5'h0C, 32'h80);
        wr(5'h0C, 32'h86);
    endtask

    task automatic set_pre(input int p1, input int p2);
        key(); wr(5'h00, DW'(p1));
        key(); wr(5'h04, DW'(p2));
    endtask

    // ticks until target output seen; other = other output seen meanwhile
    task automatic measure(input bit want_rst, output int n, output bit other);
        n = 0; other = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (want_rst ? rst_req_o : irq_o) begin
                tick_i = 1'b0;
                return;
            end
            if (want_rst ? irq_o : rst_req_o) other = 1'b1;
            tick_i = 1'b1;
            n++;
        end
        tick_i = 1'b0;
        n = -1;
    endtask

    task automatic run_ticks(input int k, output bit saw_irq, output bit saw_rst);
        saw_irq = 1'b0; saw_rst = 1'b0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            saw_irq |= irq_o; saw_rst |= rst_req_o;
            tick_i = 1'b1;
        end
        @(negedge clk);
        saw_irq |= irq_o; saw_rst |= rst_req_o;
        tick_i = 1'b0;
    endtask

    initial begin
        int v, n;
        bit oth, si, sr;
        do_reset();

        // R4 reset state
        @(negedge clk);
        rd(5'h0C, v); check(v == 0, "R4 flag read", v, 0);
        rd(5'h10, v); check(v == 0, "R4 cfg read", v, 0);
        rd(5'h14, v); check(v == 0, "R4 mode read", v, 0);
        check(irq_o == 0 && rst_req_o == 0, "R4 outputs", {irq_o, rst_req_o}, 0);
        wr(5'h10, 32'h4);
        wr(5'h14, 32'h2);
        run_ticks(60, si, sr);
        check(!si && !sr, "R4 preload 0xFFFFF no early expiry", si, 0);
        wr(5'h14, 32'h0);

        // R9 R10 R3 sweep at fast rate
        for (int p1 = 0; p1 < 4; p1++) begin
            for (int p2 = 0; p2 < 4; p2++) begin
                set_pre(p1, p2);
                wr(5'h14, 32'h2);
                measure(1'b0, n, oth);
                check(n == p1 + 1, "R9 stage one ticks", n, p1 + 1);
                measure(1'b1, n, oth);
                check(n == p2 + 1, "R10 stage two ticks", n, p2 + 1);
                rd(5'h0C, v); check(v == 32'h1200, "R6 flag set", v, 32'h1200);
                wr(5'h14, 32'h0);
                key(); wr(5'h0C, 32'h200);
            end
        end

        // R6 clear needs key; bit9 and bit12
        set_pre(1, 1);
        wr(5'h14, 32'h2);
        measure(1'b1, n, oth);
        wr(5'h14, 32'h0);
        wr(5'h0C, 32'h200);
        rd(5'h0C, v); check(v == 32'h1200, "R6 clear without key ignored", v, 32'h1200);
        key(); wr(5'h0C, 32'h200);
        rd(5'h0C, v); check(v == 0, "R6 clear via bit9", v, 0);
        wr(5'h14, 32'h2);
        measure(1'b1, n, oth);
        wr(5'h14, 32'h0);
        rd(5'h0C, v); check(v == 32'h1200, "R6 flag set again", v, 32'h1200);
        key(); wr(5'h0C, 32'h1000);
        rd(5'h0C, v); check(v == 0, "R6 clear via bit12", v, 0);

        // R3 mask to 20 bits
        key(); wr(5'h00, 32'hFFF0_0002);
        wr(5'h14, 32'h2);
        measure(1'b0, n, oth);
        check(n == 3, "R3 preload masked", n, 3);
        wr(5'h14, 32'h0);

        // R1 lone second key ignored
        wr(5'h0C, 32'h86); wr(5'h00, 32'h0);
        wr(5'h14, 32'h2); measure(1'b0, n, oth);
        check(n == 3, "R1 lone 0x86 rejected", n, 3);
        wr(5'h14, 32'h0);
        // R2 stray write between keys
        wr(5'h0C, 32'h80); wr(5'h04, 32'h7); wr(5'h0C, 32'h86); wr(5'h00, 32'h0);
        wr(5'h14, 32'h2); measure(1'b0, n, oth);
        check(n == 3, "R2 stray write closes", n, 3);
        wr(5'h14, 32'h0);
        // R2 key consumed by accepted write
        key(); wr(5'h00, 32'h1); wr(5'h00, 32'h4);
        wr(5'h14, 32'h2); measure(1'b0, n, oth);
        check(n == 2, "R2 key consumed", n, 2);
        wr(5'h14, 32'h0);

        // R5 kick in stage one, in stage two, and without key
        set_pre(5, 3);
        wr(5'h14, 32'h2);
        run_ticks(3, si, sr);
        key(); wr(5'h0C, 32'h100);
        measure(1'b0, n, oth);
        check(n == 6, "R5 kick stage one", n, 6);
        run_ticks(2, si, sr);
        key(); wr(5'h0C, 32'h100);
        measure(1'b0, n, oth);
        check(n == 6 && !oth && !sr, "R5 kick stage two", n, 6);
        wr(5'h14, 32'h0);
        wr(5'h14, 32'h2);
        run_ticks(3, si, sr);
        wr(5'h0C, 32'h100);
        measure(1'b0, n, oth);
        check(n == 3, "R5 kick without key ignored", n, 3);
        wr(5'h14, 32'h0);
        key(); wr(5'h0C, 32'h200);

        // R7 reboot disabled
        wr(5'h10, 32'h24);
        rd(5'h10, v); check(v == 32'h24, "R7 cfg readback", v, 32'h24);
        set_pre(1, 1);
        wr(5'h14, 32'h2);
        run_ticks(6, si, sr);
        rd(5'h0C, v);
        check(si && !sr && v == 32'h1200, "R7 reboot disabled no reset", sr, 0);
        wr(5'h14, 32'h0);
        key(); wr(5'h0C, 32'h200);
        wr(5'h10, 32'h4);

        // R8 free-run blocks reset
        wr(5'h14, 32'h6);
        rd(5'h14, v); check(v == 6, "R8 mode readback", v, 6);
        run_ticks(6, si, sr);
        rd(5'h0C, v);
        check(si && !sr && v == 32'h1200, "R8 free-run no reset", sr, 0);
        wr(5'h14, 32'h0);
        key(); wr(5'h0C, 32'h200);

        // R12 slow rate
        wr(5'h10, 32'h0);
        for (int p1 = 0; p1 < 3; p1++) begin
            set_pre(p1, 1);
            wr(5'h14, 32'h2);
            measure(1'b0, n, oth);
            check(n == (p1 + 1) * DIV, "R12 slow stage one", n, (p1 + 1) * DIV);
            measure(1'b1, n, oth);
            check(n == 2 * DIV, "R12 slow stage two", n, 2 * DIV);
            wr(5'h14, 32'h0);
        end

        // R11 lock
        wr(5'h14, 32'h3);
        rd(5'h14, v); check(v == 3, "R11 lock set", v, 3);
        wr(5'h14, 32'h0);
        rd(5'h14, v); check(v == 3, "R11 disable ignored", v, 3);
        wr(5'h14, 32'h4);
        rd(5'h14, v); check(v == 3, "R11 free-run ignored", v, 3);
        do_reset();
        @(negedge clk);
        rd(5'h14, v); check(v == 0, "R4 reset clears lock", v, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule